// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This unit gathers the interrupt conditions of one serial channel and reports the single most urgent one through an 8-bit status byte. It also drives an interrupt line. Three sources are plain levels that stay pending while their condition holds: a receive line error, receive data available, and receive timeout. Three more are strobes held in sticky latches until software reads the status byte while that source is the one shown: transmit holding empty, modem status change, and CTS/RTS change. A flow-control pause indication, set by an Xoff or special-character strobe, stays held until an Xon strobe arrives. Reads do not clear it.

Software reads the byte on `rd_stb`. Bit 0 is an active-low "pending" flag. Bits 5:1 identify the source, and bits 7:6 mirror the FIFO-enable flag. A read clears only the source that byte reported. If a lower source is still pending, it shows on the next read. The two highest code bits, for the pause and CTS/RTS sources, exist only while the enhanced-feature enable is set.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, with all inputs low, `status` reads 8'h01 and `irq` is 0.
- R2: `status[5:0]` shows the reported source as follows: line error 000110, data ready 000100, receive timeout 001100, transmit empty 000010, modem change 000000, pause (Xoff/special) 010000, CTS/RTS change 100000, and nothing pending 000001.
- R3: Priority, from highest to lowest, is: line error; receive timeout then data ready (same level, and timeout is shown when both are active); transmit empty; modem change; pause; CTS/RTS change. Only the highest pending source is shown.
- R4: `status[7]` and `status[6]` both equal `fifo_en`.
- R5: `status[0]` is 0 exactly when a source is pending. `irq` is the inverse of `status[0]`, registered, and lags it by one clock.
- R6: The line error, data ready and timeout sources follow their inputs combinationally, and a read does not clear them.
- R7: A transmit-empty, modem or CTS/RTS strobe sets its latch at the next clock edge, and only when its enable bit is 1. While the enable is 0 the strobe has no effect.
- R8: A read clears only the latched source being reported, at that clock edge. The next lower pending source is shown afterward.
- R9: A strobe for the reported source that arrives in the same cycle as the read sets the latch again, so the event is kept.
- R10: While `ext_en` is 0, pause and CTS/RTS strobes are ignored and `status[5:4]` reads 0.
- R11: The pause indication stays set, across reads, until `xon_stb`. If the pause and Xon strobes coincide, Xon wins.
- R12: The line error source is gated by `en_line`, and both receive sources are gated by `en_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lsr_err | input | 1 | Receive line error condition (level) |
| rx_ready | input | 1 | Receive data available (level) |
| rx_timeout | input | 1 | Receive timeout condition (level) |
| txe_stb | input | 1 | Transmit holding empty event |
| modem_stb | input | 1 | Modem status change event |
| xoff_stb | input | 1 | Pause / special character detected event |
| xon_stb | input | 1 | Resume character detected event |
| flow_stb | input | 1 | CTS/RTS change event |
| en_line | input | 1 | Line error enable |
| en_rx | input | 1 | Receive data and timeout enable |
| en_tx | input | 1 | Transmit empty enable |
| en_modem | input | 1 | Modem change enable |
| en_xoff | input | 1 | Pause indication enable |
| en_flow | input | 1 | CTS/RTS change enable |
| ext_en | input | 1 | Enhanced-feature enable |
| fifo_en | input | 1 | FIFOs enabled flag |
| rd_stb | input | 1 | Status byte read strobe |
| status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The level sources and `fifo_en` reach `status` in the same cycle, so the bench drives them on a falling edge and checks a moment later. Latched sources, and the clearing done by a read, take effect at the next rising edge, so those checks wait for the following falling edge. `irq` takes one more register stage. It is sampled one falling edge after `status` changes, and is also checked to still hold its old value just before that edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXRDY,
        SRC_RXTMO,
        SRC_TXE,
        SRC_MODEM,
        SRC_XOFF,
        SRC_FLOW
    } src_e;

    // Indices into the sticky latch bank
    localparam int STK_TXE   = 0;
    localparam int STK_MODEM = 1;
    localparam int STK_FLOW  = 2;
    localparam int NUM_STK   = 3;

    localparam int CODE_W = 6;

    function automatic logic [CODE_W-1:0] src_code(src_e s);
        logic [CODE_W-1:0] c;
        case (s)
            SRC_LINE:  c = 6'b000110;
            SRC_RXRDY: c = 6'b000100;
            SRC_RXTMO: c = 6'b001100;
            SRC_TXE:   c = 6'b000010;
            SRC_MODEM: c = 6'b000000;
            SRC_XOFF:  c = 6'b010000;
            SRC_FLOW:  c = 6'b100000;
            default:   c = 6'b000001;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uirq_sticky_bank.sv
module uirq_sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: an event always lands in its latch
        a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]);
        // R8: a clear with no coinciding event empties the latch
        a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    end

endmodule

// File: rtl/uirq_xoff_hold.sv
module uirq_xoff_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic xon_i,
    output logic held_o
);

    typedef struct packed {
        logic held;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xon_i)      st_d.held = 1'b0;
        else if (set_i) st_d.held = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;

    // R11: held until resume, resume wins
    a_r11_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !xon_i) |=> held_o);
    a_r11_xon_wins: assert property (@(posedge clk) disable iff (!rst_n)
        xon_i |=> !held_o);

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic              line_i,
    input  logic              rxrdy_i,
    input  logic              rxtmo_i,
    input  logic              txe_i,
    input  logic              modem_i,
    input  logic              xoff_i,
    input  logic              flow_i,
    output src_e              src_o,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        if (line_i)       src_o = SRC_LINE;
        else if (rxtmo_i) src_o = SRC_RXTMO;
        else if (rxrdy_i) src_o = SRC_RXRDY;
        else if (txe_i)   src_o = SRC_TXE;
        else if (modem_i) src_o = SRC_MODEM;
        else if (xoff_i)  src_o = SRC_XOFF;
        else if (flow_i)  src_o = SRC_FLOW;
        else              src_o = SRC_NONE;
        code_o = src_code(src_o);
    end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lsr_err,
    input  logic       rx_ready,
    input  logic       rx_timeout,
    input  logic       txe_stb,
    input  logic       modem_stb,
    input  logic       xoff_stb,
    input  logic       xon_stb,
    input  logic       flow_stb,
    input  logic       en_line,
    input  logic       en_rx,
    input  logic       en_tx,
    input  logic       en_modem,
    input  logic       en_xoff,
    input  logic       en_flow,
    input  logic       ext_en,
    input  logic       fifo_en,
    input  logic       rd_stb,
    output logic [7:0] status,
    output logic       irq
);

    typedef struct packed {
        logic irq;
        logic past_ok;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_STK-1:0] stk_set, stk_clr, stk_pend;
    logic               xoff_held;
    src_e               cur_src;
    logic [CODE_W-1:0]  cur_code;

    // latch set conditions
    always_comb begin
        stk_set            = '0;
        stk_set[STK_TXE]   = txe_stb   & en_tx;
        stk_set[STK_MODEM] = modem_stb & en_modem;
        stk_set[STK_FLOW]  = flow_stb  & en_flow & ext_en;
    end

    // clear only the latch behind the value being read
    always_comb begin
        stk_clr            = '0;
        stk_clr[STK_TXE]   = rd_stb & (cur_src == SRC_TXE);
        stk_clr[STK_MODEM] = rd_stb & (cur_src == SRC_MODEM);
        stk_clr[STK_FLOW]  = rd_stb & (cur_src == SRC_FLOW);
    end

    uirq_sticky_bank #(.N(NUM_STK)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stk_set),
        .clr_i  (stk_clr),
        .pend_o (stk_pend)
    );

    uirq_xoff_hold u_xoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (xoff_stb & en_xoff & ext_en),
        .xon_i  (xon_stb),
        .held_o (xoff_held)
    );

    uirq_prio_enc u_enc (
        .line_i  (lsr_err & en_line),
        .rxrdy_i (rx_ready & en_rx),
        .rxtmo_i (rx_timeout & en_rx),
        .txe_i   (stk_pend[STK_TXE]),
        .modem_i (stk_pend[STK_MODEM]),
        .xoff_i  (xoff_held & ext_en),
        .flow_i  (stk_pend[STK_FLOW] & ext_en),
        .src_o   (cur_src),
        .code_o  (cur_code)
    );

    assign status = {fifo_en, fifo_en, cur_code};

    always_comb begin
        st_d         = st_q;
        st_d.irq     = ~cur_code[0];
        st_d.past_ok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R5: interrupt line lags the pending flag by one clock
    a_r5_irq_lags: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.past_ok |-> (irq == !$past(status[0])));
    // R5: pending flag consistent with source bits
    a_r5_bit0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (status[5:1] == 5'b0));
    // R10: extended codes absent while the enhanced feature is off
    a_r10_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> (status[5:4] == 2'b00));
    // R3: at most one source bit of the extended pair is shown
    a_r3_single_ext: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status[5:4]) <= 1);

endmodule

// File: tb/sim_uart_irq_status.sv
module sim_uart_irq_status;

    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 200000;

    logic clk = 0;
    logic rst_n = 0;
    logic lsr_err = 0, rx_ready = 0, rx_timeout = 0;
    logic txe_stb = 0, modem_stb = 0, xoff_stb = 0, xon_stb = 0, flow_stb = 0;
    logic en_line = 1, en_rx = 1, en_tx = 1, en_modem = 1, en_xoff = 1, en_flow = 1;
    logic ext_en = 1, fifo_en = 0, rd_stb = 0;
    logic [7:0] status;
    logic irq;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_status u0 (
        .clk(clk), .rst_n(rst_n),
        .lsr_err(lsr_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .txe_stb(txe_stb), .modem_stb(modem_stb), .xoff_stb(xoff_stb),
        .xon_stb(xon_stb), .flow_stb(flow_stb),
        .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx), .en_modem(en_modem),
        .en_xoff(en_xoff), .en_flow(en_flow),
        .ext_en(ext_en), .fifo_en(fifo_en), .rd_stb(rd_stb),
        .status(status), .irq(irq)
    );

    // {fifo_en, ext_en, lsr_err, rx_ready, rx_timeout, expected status}
    localparam logic [12:0] VECS [0:7] = '{
        {5'b00000, 8'h01},
        {5'b10000, 8'hC1},
        {5'b00100, 8'h06},
        {5'b00010, 8'h04},
        {5'b00001, 8'h0C},
        {5'b00011, 8'h0C},
        {5'b11111, 8'hC6},
        {5'b10010, 8'hC4}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one event strobe, registered at the next rising edge; returns at the following falling edge
    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1;
        @(negedge clk); rd_stb = 0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1 status", status, 8'h01);
        check("R1 irq", {7'b0, irq}, 8'h00);
        @(negedge clk); rst_n = 1;
        settle();
        check("R1 after release", status, 8'h01);

        // R2/R3/R4/R6: level source table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {fifo_en, ext_en, lsr_err, rx_ready, rx_timeout} = VECS[i][12:8];
            #1;
            check("R2/R3/R4 table", status, VECS[i][7:0]);
        end
        @(negedge clk);
        {fifo_en, lsr_err, rx_ready, rx_timeout} = '0; ext_en = 1;
        settle();

        // R5: irq lags status by one clock
        @(negedge clk); lsr_err = 1; #1;
        check("R5 status pending", status, 8'h06);
        check("R5 irq not yet", {7'b0, irq}, 8'h00);
        @(negedge clk); #1;
        check("R5 irq raised", {7'b0, irq}, 8'h01);

        // R6: read does not clear a level source
        do_read(); #1;
        check("R6 level survives read", status, 8'h06);
        @(negedge clk); lsr_err = 0; #1;
        check("R6 follows input", status, 8'h01);
        @(negedge clk); #1;
        check("R5 irq dropped", {7'b0, irq}, 8'h00);

        // R12: enables gate level sources
        @(negedge clk); en_line = 0; lsr_err = 1; en_rx = 0; rx_timeout = 1; #1;
        check("R12 disabled levels", status, 8'h01);
        @(negedge clk); en_line = 1; lsr_err = 0; en_rx = 1; rx_timeout = 0;

        // R7: disabled strobe ignored, enabled one latched
        en_tx = 0; pulse(txe_stb); #1;
        check("R7 disabled tx", status, 8'h01);
        en_tx = 1; pulse(txe_stb); #1;
        check("R7 tx latched", status, 8'h02);

        // R3: data ready hides tx latch
        @(negedge clk); rx_ready = 1; #1;
        check("R3 rx over tx", status, 8'h04);
        @(negedge clk); rx_ready = 0; #1;
        check("R3 tx revealed", status, 8'h02);

        // R8: read clears reported latch only
        pulse(modem_stb); #1;
        check("R8 tx before modem", status, 8'h02);
        do_read(); #1;
        check("R8 modem next", status, 8'h00);
        do_read(); #1;
        check("R8 all cleared", status, 8'h01);

        // R9: event during read kept
        pulse(txe_stb);
        @(negedge clk); rd_stb = 1; txe_stb = 1;
        @(negedge clk); rd_stb = 0; txe_stb = 0; #1;
        check("R9 event kept", status, 8'h02);
        do_read(); #1;
        check("R9 later read clears", status, 8'h01);

        // R10: enhanced sources ignored while off
        ext_en = 0;
        pulse(flow_stb); #1;
        check("R10 flow ignored", status, 8'h01);
        pulse(xoff_stb); #1;
        check("R10 xoff ignored", status, 8'h01);
        ext_en = 1; #1;
        check("R10 nothing stored", status, 8'h01);
        pulse(flow_stb); #1;
        check("R2 flow code", status, 8'h20);

        // R11: pause held across reads, beats flow, cleared by xon
        pulse(xoff_stb); #1;
        check("R3 xoff over flow", status, 8'h10);
        do_read(); #1;
        check("R11 survives read", status, 8'h10);
        pulse(xon_stb); #1;
        check("R11 xon clears", status, 8'h20);
        do_read(); #1;
        check("R8 flow cleared", status, 8'h01);
        @(negedge clk); xoff_stb = 1; xon_stb = 1;
        @(negedge clk); xoff_stb = 0; xon_stb = 0; #1;
        check("R11 xon wins", status, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule